// File: doc/BRIEF.md
# Banked Indirect Priority Configuration Table

This block holds two priority values for every partition ID: one used inside the owning component and one attached to requests it forwards downstream. Software reaches the table indirectly. Each of four security-space banks (Secure, Non-secure, Root, Realm) has its own selector register, which names a partition ID and, when several resource instances exist, an instance number. The same bank also has a priority data register. Software first writes the selector and then reads or writes the data register. That access reaches the entry the selector names. The four banks share no state.

Parameters decide several things. They say whether each priority field exists and how many bits it keeps. They say whether resource instances are indexed, whether the whole priority feature is present, whether the Root and Realm banks are usable, and whether partition-ID narrowing is in force. A consumer reads any entry combinationally through a separate lookup port, with no bus access involved.

Top module: `prio_cfg_table`

## Requirements
- R1: Each bank has a selector at offset 0x100 with this layout: partition ID in bits [15:0], an INTERNAL flag in bit 16, and a resource instance in bits [27:24]. A read returns the stored fields and zero in every other bit. A write to one bank's selector leaves the other banks unchanged.
- R2: Each bank has a data register at offset 0x400 with this layout: downstream priority in bits [31:16], internal priority in bits [15:0]. Reads and writes reach the entry chosen by that bank's own selector. Banks are selected by reg_bank as 0 = Secure, 1 = Non-secure, 2 = Root, 3 = Realm.
- R3: With HAS_INST set, the entry is chosen by both the instance and the partition ID. Without it, the instance field is ignored, reads back as zero, and every access uses instance 0.
- R4: A priority field stores only its INT_W or DS_W least significant bits. The bits above that width read as zero.
- R5: A priority field whose HAS_INT or HAS_DS parameter is 0 reads as zero and ignores writes.
- R6: With HAS_FEATURE at 0, the data register of every bank reads as zero and ignores writes.
- R7: With HAS_REALM at 0, the Root and Realm banks read as zero and ignore writes, in both their selector and their data register.
- R8: A data access is valid only when the selector's INTERNAL flag equals HAS_NARROW. Otherwise it reads as zero and the write is discarded.
- R9: A partition ID at or above NUM_PART, or an instance at or above NUM_INST, makes the data register read as zero and discard writes. The stored table stays unchanged.
- R10: reg_rdata is registered. It is valid in the cycle after a read strobe and holds its value while no read is issued. Reads of any offset other than 0x100 and 0x400 return zero.
- R11: The lookup port returns the stored priorities, zero-extended to 16 bits, for the given bank, partition ID and instance. It changes only after a table write or a change of its inputs. An out-of-range partition ID or instance returns zero.
- R12: After reset, every table entry and every selector is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_bank | input | 2 | Security-space bank of the access |
| reg_addr | input | ADDR_W | Byte offset within the bank |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the strobe |
| lk_bank | input | 2 | Lookup bank |
| lk_part | input | 16 | Lookup partition ID |
| lk_inst | input | 4 | Lookup resource instance |
| lk_int_prio | output | 16 | Internal priority of the looked-up entry |
| lk_ds_prio | output | 16 | Downstream priority of the looked-up entry |

## Verification
A register read returns its data one clock edge after the strobe. The bench therefore drives every access on a falling edge and compares reg_rdata at the next falling edge, and for hold checks it compares again after one more idle cycle. A selector or table write takes effect at the edge that captures it. The next access therefore sees the new value, and the lookup outputs are compared shortly after the following falling edge, once the combinational path has settled. Three instances with different parameter sets receive the same stimulus, and each is checked against its own bench model.

// File: rtl/prio_cfg_pkg.sv
package prio_cfg_pkg;
    localparam int NUM_BANKS = 4;
    localparam int FIELD_W   = 16;
    localparam int SEL_OFF   = 'h100;
    localparam int PRI_OFF   = 'h400;

    typedef enum logic [1:0] {
        BANK_SEC  = 2'd0,
        BANK_NSEC = 2'd1,
        BANK_ROOT = 2'd2,
        BANK_RLM  = 2'd3
    } bank_e;

    typedef struct packed {
        logic [3:0]  inst;
        logic        internal;
        logic [15:0] part;
    } sel_t;
endpackage

// File: rtl/prio_cfg_sel_bank.sv
module prio_cfg_sel_bank
    import prio_cfg_pkg::*;
#(
    parameter int BANK_EN  = 1,
    parameter int HAS_INST = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  sel_t wr_sel,
    output sel_t sel
);
    sel_t sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        if (wr_en && (BANK_EN != 0)) begin
            sel_d = wr_sel;
            if (HAS_INST == 0) begin
                sel_d.inst = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign sel = sel_q;
endmodule

// File: rtl/prio_cfg_decode.sv
module prio_cfg_decode #(
    parameter int NUM_PART    = 16,
    parameter int NUM_INST    = 4,
    parameter int INST_N      = 4,
    parameter int HAS_INST    = 1,
    parameter int HAS_FEATURE = 1,
    parameter int HAS_REALM   = 1,
    parameter int HAS_NARROW  = 0,
    parameter int IDX_W       = 8
) (
    input  logic [1:0]       bank,
    input  logic [15:0]      part,
    input  logic [3:0]       inst,
    input  logic             internal,
    input  logic             chk_internal,
    output logic             ok,
    output logic [IDX_W-1:0] idx
);
    logic [3:0]  inst_eff;
    logic        bank_en;
    logic        part_in;
    logic        inst_in;
    logic        flag_ok;
    logic [31:0] idx_full;

    always_comb begin
        inst_eff = (HAS_INST != 0) ? inst : 4'd0;
        bank_en  = (bank[1] == 1'b0) || (HAS_REALM != 0);
        part_in  = 32'(part) < NUM_PART;
        inst_in  = (HAS_INST == 0) || (32'(inst_eff) < NUM_INST);
        flag_ok  = !chk_internal || (internal == (HAS_NARROW != 0));
        ok       = (HAS_FEATURE != 0) && bank_en && part_in && inst_in && flag_ok;
        idx_full = (32'(bank) * INST_N + 32'(inst_eff)) * NUM_PART + 32'(part);
        idx      = ok ? IDX_W'(idx_full) : '0;
    end
endmodule

// File: rtl/prio_cfg_store.sv
module prio_cfg_store #(
    parameter int NUM_ENT = 256,
    parameter int IDX_W   = 8,
    parameter int INT_W   = 8,
    parameter int DS_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [INT_W-1:0] wr_int,
    input  logic [DS_W-1:0]  wr_ds,
    input  logic [IDX_W-1:0] a_idx,
    output logic [INT_W-1:0] a_int,
    output logic [DS_W-1:0]  a_ds,
    input  logic [IDX_W-1:0] b_idx,
    output logic [INT_W-1:0] b_int,
    output logic [DS_W-1:0]  b_ds
);
    typedef struct packed {
        logic [NUM_ENT-1:0][INT_W-1:0] ip;
        logic [NUM_ENT-1:0][DS_W-1:0]  dp;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d.ip[wr_idx] = wr_int;
            tbl_d.dp[wr_idx] = wr_ds;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign a_int = tbl_q.ip[a_idx];
    assign a_ds  = tbl_q.dp[a_idx];
    assign b_int = tbl_q.ip[b_idx];
    assign b_ds  = tbl_q.dp[b_idx];
endmodule

// File: rtl/prio_cfg_table.sv
module prio_cfg_table
    import prio_cfg_pkg::*;
#(
    parameter int NUM_PART    = 16,
    parameter int NUM_INST    = 4,
    parameter int HAS_INST    = 1,
    parameter int HAS_INT     = 1,
    parameter int INT_W       = 8,
    parameter int HAS_DS      = 1,
    parameter int DS_W        = 4,
    parameter int HAS_FEATURE = 1,
    parameter int HAS_REALM   = 1,
    parameter int HAS_NARROW  = 0,
    parameter int ADDR_W      = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [1:0]        reg_bank,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [1:0]        lk_bank,
    input  logic [15:0]       lk_part,
    input  logic [3:0]        lk_inst,
    output logic [15:0]       lk_int_prio,
    output logic [15:0]       lk_ds_prio
);
    localparam int INST_N  = (HAS_INST != 0) ? NUM_INST : 1;
    localparam int NUM_ENT = NUM_BANKS * INST_N * NUM_PART;
    localparam int IDX_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

    typedef struct packed {
        logic [31:0] rdata;
    } rd_state_t;

    sel_t                 sel_arr [NUM_BANKS];
    logic [NUM_BANKS-1:0] sel_wr;
    sel_t                 wsel;
    sel_t                 cur_sel;
    logic                 sel_hit;
    logic                 pri_hit;
    logic                 bus_ok;
    logic [IDX_W-1:0]     bus_idx;
    logic                 lk_ok;
    logic [IDX_W-1:0]     lk_idx;
    logic                 tbl_wr;
    logic [INT_W-1:0]     wr_int;
    logic [DS_W-1:0]      wr_ds;
    logic [INT_W-1:0]     a_int;
    logic [DS_W-1:0]      a_ds;
    logic [INT_W-1:0]     b_int;
    logic [DS_W-1:0]      b_ds;
    logic [31:0]          sel_word;
    logic [31:0]          pri_word;
    rd_state_t            rd_d, rd_q;

    // address decode and write-data split
    assign sel_hit       = reg_addr == ADDR_W'(SEL_OFF);
    assign pri_hit       = reg_addr == ADDR_W'(PRI_OFF);
    assign wsel.part     = reg_wdata[15:0];
    assign wsel.internal = reg_wdata[16];
    assign wsel.inst     = reg_wdata[27:24];

    // one selector register per security-space bank
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign sel_wr[b] = reg_en && reg_we && sel_hit && (reg_bank == 2'(b));
        prio_cfg_sel_bank #(
            .BANK_EN  (((b < 2) || (HAS_REALM != 0)) ? 1 : 0),
            .HAS_INST (HAS_INST)
        ) u_sel (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (sel_wr[b]),
            .wr_sel (wsel),
            .sel    (sel_arr[b])
        );
    end

    assign cur_sel = sel_arr[reg_bank];

    prio_cfg_decode #(
        .NUM_PART (NUM_PART), .NUM_INST (NUM_INST), .INST_N (INST_N),
        .HAS_INST (HAS_INST), .HAS_FEATURE (HAS_FEATURE),
        .HAS_REALM (HAS_REALM), .HAS_NARROW (HAS_NARROW), .IDX_W (IDX_W)
    ) u_bus_dec (
        .bank         (reg_bank),
        .part         (cur_sel.part),
        .inst         (cur_sel.inst),
        .internal     (cur_sel.internal),
        .chk_internal (1'b1),
        .ok           (bus_ok),
        .idx          (bus_idx)
    );

    prio_cfg_decode #(
        .NUM_PART (NUM_PART), .NUM_INST (NUM_INST), .INST_N (INST_N),
        .HAS_INST (HAS_INST), .HAS_FEATURE (HAS_FEATURE),
        .HAS_REALM (HAS_REALM), .HAS_NARROW (HAS_NARROW), .IDX_W (IDX_W)
    ) u_lk_dec (
        .bank         (lk_bank),
        .part         (lk_part),
        .inst         (lk_inst),
        .internal     (1'b0),
        .chk_internal (1'b0),
        .ok           (lk_ok),
        .idx          (lk_idx)
    );

    // absent fields store zero
    assign tbl_wr = reg_en && reg_we && pri_hit && bus_ok;
    assign wr_int = (HAS_INT != 0) ? reg_wdata[INT_W-1:0] : '0;
    assign wr_ds  = (HAS_DS != 0) ? reg_wdata[16 +: DS_W] : '0;

    prio_cfg_store #(
        .NUM_ENT (NUM_ENT), .IDX_W (IDX_W), .INT_W (INT_W), .DS_W (DS_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tbl_wr),
        .wr_idx (bus_idx),
        .wr_int (wr_int),
        .wr_ds  (wr_ds),
        .a_idx  (bus_idx),
        .a_int  (a_int),
        .a_ds   (a_ds),
        .b_idx  (lk_idx),
        .b_int  (b_int),
        .b_ds   (b_ds)
    );

    assign sel_word = {4'b0, cur_sel.inst, 7'b0, cur_sel.internal, cur_sel.part};
    assign pri_word = bus_ok ? {((HAS_DS != 0) ? 16'(a_ds) : 16'd0),
                                ((HAS_INT != 0) ? 16'(a_int) : 16'd0)} : 32'd0;

    always_comb begin
        rd_d = rd_q;
        if (reg_en && !reg_we) begin
            if (sel_hit) begin
                rd_d.rdata = sel_word;
            end else if (pri_hit) begin
                rd_d.rdata = pri_word;
            end else begin
                rd_d.rdata = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign reg_rdata   = rd_q.rdata;
    assign lk_int_prio = (lk_ok && (HAS_INT != 0)) ? 16'(b_int) : 16'd0;
    assign lk_ds_prio  = (lk_ok && (HAS_DS != 0)) ? 16'(b_ds) : 16'd0;
endmodule

// File: rtl/prio_cfg_checker.sv
module prio_cfg_checker #(
    parameter int NUM_PART    = 16,
    parameter int HAS_DS      = 1,
    parameter int INT_W       = 8,
    parameter int HAS_FEATURE = 1,
    parameter int HAS_REALM   = 1,
    parameter int ADDR_W      = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_en,
    input logic              reg_we,
    input logic [1:0]        reg_bank,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_rdata,
    input logic [1:0]        lk_bank,
    input logic [15:0]       lk_part,
    input logic [3:0]        lk_inst,
    input logic [15:0]       lk_int_prio,
    input logic [15:0]       lk_ds_prio
);
    logic rd_any;
    logic rd_pri;
    logic rd_other;

    assign rd_any   = reg_en && !reg_we;
    assign rd_pri   = rd_any && (reg_addr == ADDR_W'('h400));
    assign rd_other = rd_any && (reg_addr != ADDR_W'('h400)) && (reg_addr != ADDR_W'('h100));

    assert_int_trunc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pri |=> ((32'(reg_rdata[15:0]) >> INT_W) == 0));

    assert_ds_absent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pri && (HAS_DS == 0)) |=> (reg_rdata[31:16] == 16'd0));

    assert_feature_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pri && (HAS_FEATURE == 0)) |=> (reg_rdata == 32'd0));

    assert_realm_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && reg_bank[1] && (HAS_REALM == 0)) |=> (reg_rdata == 32'd0));

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_other |=> (reg_rdata == 32'd0));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_any |=> $stable(reg_rdata));

    assert_lk_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(lk_part) >= NUM_PART) |-> (lk_int_prio == 16'd0 && lk_ds_prio == 16'd0));

    assert_lk_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(reg_en && reg_we) && $stable(lk_bank) && $stable(lk_part) && $stable(lk_inst))
        |-> ($stable(lk_int_prio) && $stable(lk_ds_prio)));

    assert_reset_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (reg_rdata == 32'd0));
endmodule

bind prio_cfg_table prio_cfg_checker #(
    .NUM_PART    (NUM_PART),
    .HAS_DS      (HAS_DS),
    .INT_W       (INT_W),
    .HAS_FEATURE (HAS_FEATURE),
    .HAS_REALM   (HAS_REALM),
    .ADDR_W      (ADDR_W)
) u_prio_cfg_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_en      (reg_en),
    .reg_we      (reg_we),
    .reg_bank    (reg_bank),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata),
    .lk_bank     (lk_bank),
    .lk_part     (lk_part),
    .lk_inst     (lk_inst),
    .lk_int_prio (lk_int_prio),
    .lk_ds_prio  (lk_ds_prio)
);

// File: tb/prio_cfg_table_bench.sv
module prio_cfg_table_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NDUT = 3;
    localparam logic [11:0] A_SEL = 12'h100;
    localparam logic [11:0] A_PRI = 12'h400;

    // per-instance parameter sets
    localparam int CF_INST  [NDUT] = '{1, 0, 1};
    localparam int CF_INT   [NDUT] = '{1, 1, 1};
    localparam int CF_IW    [NDUT] = '{8, 16, 5};
    localparam int CF_DS    [NDUT] = '{1, 0, 1};
    localparam int CF_DW    [NDUT] = '{4, 4, 16};
    localparam int CF_FEAT  [NDUT] = '{1, 1, 0};
    localparam int CF_REALM [NDUT] = '{1, 0, 1};
    localparam int CF_NARR  [NDUT] = '{0, 1, 0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_bank = '0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  lk_bank = '0;
    logic [15:0] lk_part = '0;
    logic [3:0]  lk_inst = '0;
    logic [31:0] rdata [NDUT];
    logic [15:0] lint  [NDUT];
    logic [15:0] lds   [NDUT];

    logic [31:0] mdl  [NDUT][4][4][16];
    logic [31:0] msel [NDUT][4];
    int nvec = 0;
    int nfail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_cfg_table u_prio_cfg_table (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_bank(reg_bank), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata[0]), .lk_bank(lk_bank), .lk_part(lk_part),
        .lk_inst(lk_inst), .lk_int_prio(lint[0]), .lk_ds_prio(lds[0]));

    prio_cfg_table #(
        .HAS_INST(0), .INT_W(16), .HAS_DS(0), .HAS_REALM(0), .HAS_NARROW(1)
    ) u_prio_cfg_table_alt (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_bank(reg_bank), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata[1]), .lk_bank(lk_bank), .lk_part(lk_part),
        .lk_inst(lk_inst), .lk_int_prio(lint[1]), .lk_ds_prio(lds[1]));

    prio_cfg_table #(
        .INT_W(5), .DS_W(16), .HAS_FEATURE(0)
    ) u_prio_cfg_table_off (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_bank(reg_bank), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata[2]), .lk_bank(lk_bank), .lk_part(lk_part),
        .lk_inst(lk_inst), .lk_int_prio(lint[2]), .lk_ds_prio(lds[2]));

    function automatic logic [15:0] fmask(int w);
        return 16'((32'd1 << w) - 1);
    endfunction

    function automatic bit bank_ok(int d, int b);
        return (b < 2) || (CF_REALM[d] != 0);
    endfunction

    function automatic bit data_ok(int d, int b);
        logic [31:0] s = msel[d][b];
        return (CF_FEAT[d] != 0) && bank_ok(d, b) && (int'(s[16]) == CF_NARR[d])
            && (s[15:0] < 16) && ((CF_INST[d] == 0) || (s[27:24] < 4));
    endfunction

    function automatic logic [31:0] exp_rd(int d, int b, logic [11:0] a);
        logic [31:0] s = msel[d][b];
        if (a == A_SEL) return s;
        if (a == A_PRI && data_ok(d, b))
            return mdl[d][b][(CF_INST[d] != 0) ? int'(s[27:24]) : 0][s[15:0]];
        return 32'd0;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic bus_wr(int b, logic [11:0] a, logic [31:0] w);
        reg_en = 1'b1; reg_we = 1'b1; reg_bank = 2'(b); reg_addr = a; reg_wdata = w;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
        for (int d = 0; d < NDUT; d++) begin
            if (a == A_SEL && bank_ok(d, b)) begin
                msel[d][b] = {4'b0, ((CF_INST[d] != 0) ? w[27:24] : 4'd0), 7'b0, w[16], w[15:0]};
            end else if (a == A_PRI && data_ok(d, b)) begin
                logic [31:0] s = msel[d][b];
                mdl[d][b][(CF_INST[d] != 0) ? int'(s[27:24]) : 0][s[15:0]] =
                    {((CF_DS[d] != 0) ? (w[31:16] & fmask(CF_DW[d])) : 16'd0),
                     ((CF_INT[d] != 0) ? (w[15:0] & fmask(CF_IW[d])) : 16'd0)};
            end
        end
    endtask

    task automatic bus_rd(int b, logic [11:0] a, string tag, bit hold);
        logic [31:0] e [NDUT];
        for (int d = 0; d < NDUT; d++) e[d] = exp_rd(d, b, a);
        reg_en = 1'b1; reg_we = 1'b0; reg_bank = 2'(b); reg_addr = a;
        @(negedge clk);
        reg_en = 1'b0;
        for (int d = 0; d < NDUT; d++) chk($sformatf("%s dut%0d bank%0d addr%h", tag, d, b, a), rdata[d], e[d]);
        if (hold) begin
            @(negedge clk);
            for (int d = 0; d < NDUT; d++) chk($sformatf("R10 hold dut%0d", d), rdata[d], e[d]);
        end
    endtask

    task automatic lk_check(int b, int p, int i);
        lk_bank = 2'(b); lk_part = 16'(p); lk_inst = 4'(i);
        #1;
        for (int d = 0; d < NDUT; d++) begin
            logic [31:0] w = 32'd0;
            int iv = (CF_INST[d] != 0) ? i : 0;
            if (p < 16 && iv < 4) w = mdl[d][b][iv][p];
            chk($sformatf("R11 lookup int dut%0d", d), {16'd0, lint[d]}, {16'd0, w[15:0]});
            chk($sformatf("R11 lookup ds dut%0d", d), {16'd0, lds[d]}, {16'd0, w[31:16]});
        end
    endtask

    function automatic logic [31:0] sel_word(int p, int i, int f);
        return {4'b0, 4'(i), 7'b0, 1'(f), 16'(p)};
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        nfail++;
        $display("FAIL watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int d = 0; d < NDUT; d++)
            for (int b = 0; b < 4; b++) begin
                msel[d][b] = '0;
                for (int i = 0; i < 4; i++)
                    for (int p = 0; p < 16; p++) mdl[d][b][i][p] = '0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state of selectors, table and lookup
        for (int b = 0; b < 4; b++) begin
            bus_rd(b, A_SEL, "R12 reset sel", 1'b0);
            bus_rd(b, A_PRI, "R12 reset data", 1'b0);
        end
        lk_check(0, 0, 0);

        // R4: truncation to implemented width, and R1 selector readback
        bus_wr(0, A_SEL, sel_word(3, 1, 0));
        bus_rd(0, A_SEL, "R1 sel readback", 1'b0);
        bus_wr(0, A_PRI, 32'hFFFF_FFFF);
        bus_rd(0, A_PRI, "R4 truncate", 1'b1);

        // R2: bank independence
        bus_wr(1, A_SEL, sel_word(3, 1, 0));
        bus_wr(1, A_PRI, 32'h0005_0042);
        bus_rd(0, A_PRI, "R2 bank0 untouched", 1'b0);
        bus_rd(1, A_PRI, "R2 bank1", 1'b0);

        // R3: different instances, same partition
        bus_wr(0, A_SEL, sel_word(3, 2, 0));
        bus_wr(0, A_PRI, 32'h0003_0011);
        bus_rd(0, A_PRI, "R3 inst2", 1'b0);
        bus_wr(0, A_SEL, sel_word(3, 1, 0));
        bus_rd(0, A_PRI, "R3 inst1", 1'b0);
        lk_check(0, 3, 2);

        // R9: out-of-range partition and instance
        bus_wr(0, A_SEL, sel_word(20, 1, 0));
        bus_wr(0, A_PRI, 32'h1234_5678);
        bus_rd(0, A_PRI, "R9 part range", 1'b0);
        bus_wr(0, A_SEL, sel_word(3, 6, 0));
        bus_wr(0, A_PRI, 32'h1234_5678);
        bus_rd(0, A_PRI, "R9 inst range", 1'b0);
        bus_wr(0, A_SEL, sel_word(3, 1, 0));
        bus_rd(0, A_PRI, "R9 table kept", 1'b0);

        // R8: flag mismatch (alt instance needs 1), R7 Root/Realm on alt
        bus_wr(2, A_SEL, sel_word(4, 0, 1));
        bus_wr(2, A_PRI, 32'h0007_00AA);
        bus_rd(2, A_PRI, "R7 root bank", 1'b0);
        bus_wr(1, A_SEL, sel_word(4, 0, 1));
        bus_wr(1, A_PRI, 32'h0009_BEEF);
        bus_rd(1, A_PRI, "R8 flag set", 1'b0);

        // R10: unmapped offset; R5/R6 are covered by the alt and off instances
        bus_rd(0, 12'h404, "R10 unmapped", 1'b1);
        bus_rd(3, A_PRI, "R5 R6 data", 1'b0);

        for (int n = 0; n < 600; n++) begin
            int b = $urandom_range(0, 3);
            int op = $urandom_range(0, 6);
            case (op)
                0: bus_wr(b, A_SEL, sel_word($urandom_range(0, 19), $urandom_range(0, 5),
                                             $urandom_range(0, 1)));
                1, 2: bus_wr(b, A_PRI, $urandom());
                3: bus_rd(b, A_PRI, "R2 R4 R5 R6 R8 R9 rand data", ($urandom_range(0, 3) == 0));
                4: bus_rd(b, A_SEL, "R1 R3 R7 rand sel", 1'b0);
                5: lk_check(b, $urandom_range(0, 19), $urandom_range(0, 5));
                default: bus_rd(b, 12'($urandom_range(0, 4095)), "R10 rand addr", 1'b0);
            endcase
            #1;
            @(negedge clk);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule